// File: doc/BRIEF.md
# Indirect Register Port for a Dual-Channel Serial Controller

This block is the host side of a two-channel serial controller. The host sees one control location per channel. A register is reached in two steps. First the host writes a selector byte to register 0. The next access to the control location then reads or writes the register that the selector named. After that access the pointer falls back to register 0. Only a selector that carries the point-high code can reach registers 8 to 15.

The register-0 write also carries commands. A three-bit command field and a two-bit reset field are decoded into a one-cycle strobe on the addressed channel. The strobe is sent to the serial datapath together with the decoded codes.

Each channel has its own write registers. The interrupt-vector register and the master-control register are one copy that both channels share. The master-control register also starts channel resets and a full reset. On the read side a multiplexer returns status bytes from the datapath and a pending-interrupt summary. It can also read back some write registers directly.

The host data bus is bidirectional. At the block edge it is split into an input byte, an output byte and an output enable, and the pad drives the bus from these.

Top module: `sio_regport`

## Requirements
- R1: A register-0 write sets the pointer from bits 2:0 (plus the point-high bit). The next control access, read or write, targets that register. Every such access returns the pointer to 0, so the access after it reaches register 0 again.
- R2: The point-high code, value 1 in bits 5:3 of the register-0 byte, adds 8 to the pointer. Without that code only registers 0 to 7 can be selected.
- R3: A register-0 write whose bits 5:3 hold a command code from 2 to 7 pulses the addressed channel's bit of `cmd_stb_o` for one cycle, in the cycle after the write. `cmd_op_o` then carries the code. Codes 0 (null) and 1 (point-high) pulse nothing.
- R4: A register-0 write with a non-zero reset code in bits 7:6 also pulses `cmd_stb_o`. The code appears on `crc_op_o`: 1 resets the receive CRC, 2 resets the transmit CRC, and 3 resets the underrun/end-of-message latch.
- R5: Write registers 2 (interrupt vector) and 9 (master control) are single copies. A write through either channel shows up at index 2 or 9 of both channels on `wreg_o`. Reading register 2 returns the vector.
- R6: Reading register 3 on channel A returns {2'b00, pend_a_i, pend_b_i}, where each 3-bit field is {receive, transmit, status}. Reading register 3 on channel B returns 0.
- R7: Reading register 15 returns write register 15 ANDed with 0xFA (bits 2 and 0 read as zero).
- R8: A master-control write with bits 7:6 = 2 clears every write register of channel A, and a write with bits 7:6 = 1 clears every write register of channel B. The shared vector is kept, and master control keeps the written bits 5:0.
- R9: A master-control write with bits 7:6 = 3 clears all write registers of both channels, including the shared vector and master control.
- R10: After reset all write registers are zero, the pointer is 0 and no command strobe is active.
- R11: Reads of registers 0, 1 and 10 return the addressed channel's byte from `dp_rr0_i`, `dp_rr1_i` and `dp_rr10_i`. Reads of 12 and 13 return the channel's write registers 12 and 13. Every other read register returns 0.
- R12: `data_oe_o` is high exactly in the cycles where `cs_i` and `rd_i` are both high.
- R13: Strobes with `cs_i` low change neither the write registers nor the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_i | input | 1 | Chip select |
| chan_i | input | 1 | Channel select: 0 = A, 1 = B |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| data_i | input | 8 | Host bus, write direction |
| data_o | output | 8 | Host bus, read direction |
| data_oe_o | output | 1 | Drive enable for the host bus |
| pend_a_i | input | 3 | Channel A pending interrupts {rx, tx, status} |
| pend_b_i | input | 3 | Channel B pending interrupts {rx, tx, status} |
| dp_rr0_i | input | 16 | Per-channel buffer/external status bytes [ch][7:0] |
| dp_rr1_i | input | 16 | Per-channel special-condition status bytes |
| dp_rr10_i | input | 16 | Per-channel miscellaneous status bytes |
| wreg_o | output | 256 | Write registers [ch][index][7:0], shared ones mirrored |
| cmd_stb_o | output | 2 | One-cycle command strobe per channel |
| cmd_op_o | output | 3 | Last command code |
| crc_op_o | output | 2 | Last reset code |

## Verification
The assertions check on every cycle that a selected access returns the pointer to 0, and that a selector without point-high never reaches the upper bank. They also check that a command strobe only follows a register-0 write and covers at most one channel. On the register side they check that channel resets leave the shared vector alone, that a full reset clears the shared copies, that RR15 masks its two bits and that channel B reads zero from the pending register. Only the bench scenarios show the rest: the full write/readback sweep over both channels, where a wrong pointer or a wrong channel would land a byte in the wrong slot; all command and reset code combinations; every pending pattern; and the effect on the registers of strobes made while the chip is not selected.

// File: rtl/sio_regport_pkg.sv
package sio_regport_pkg;

    localparam int DATA_W_DEF = 8;
    localparam int NUM_REGS_DEF = 16;
    localparam int NUM_CH = 2;

    // Command field (bits 5:3 of the register-0 byte)
    localparam logic [2:0] OP_NULL       = 3'd0;
    localparam logic [2:0] OP_POINT_HIGH = 3'd1;

    // Reset request field of master control (bits 7:6)
    localparam logic [1:0] MRST_NONE = 2'd0;
    localparam logic [1:0] MRST_CH_B = 2'd1;
    localparam logic [1:0] MRST_CH_A = 2'd2;
    localparam logic [1:0] MRST_ALL  = 2'd3;

    // Register indices whose meaning the block decodes
    localparam int IDX_STAT0  = 0;
    localparam int IDX_STAT1  = 1;
    localparam int IDX_VEC    = 2;
    localparam int IDX_PEND   = 3;
    localparam int IDX_MCTL   = 9;
    localparam int IDX_MISC   = 10;
    localparam int IDX_BRG_LO = 12;
    localparam int IDX_BRG_HI = 13;
    localparam int IDX_EXTCFG = 15;

    localparam logic [7:0] EXTCFG_RD_MASK = 8'hFA;
    localparam logic [7:0] MCTL_KEEP_MASK = 8'h3F;

endpackage

// File: rtl/sio_ptr_seq.sv
module sio_ptr_seq
    import sio_regport_pkg::*;
#(
    parameter int DATA_W   = DATA_W_DEF,
    parameter int NUM_REGS = NUM_REGS_DEF,
    localparam int PW      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              chan_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [PW-1:0]     ptr_o,
    output logic              reg_we_o,
    output logic [NUM_CH-1:0] cmd_stb_o,
    output logic [2:0]        cmd_op_o,
    output logic [1:0]        crc_op_o
);

    typedef struct packed {
        logic [PW-1:0]     ptr;
        logic [NUM_CH-1:0] cmd_stb;
        logic [2:0]        cmd_op;
        logic [1:0]        crc_op;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [2:0] op_field;
    logic [1:0] rst_field;
    logic       at_base;

    assign op_field  = data_i[5:3];
    assign rst_field = data_i[7:6];
    assign at_base   = (st_q.ptr == '0);

    always_comb begin
        st_d = st_q;
        st_d.cmd_stb = '0;
        if (cs_i && wr_i) begin
            if (at_base) begin
                st_d.ptr = PW'({(op_field == OP_POINT_HIGH), data_i[2:0]});
                if (((op_field != OP_NULL) && (op_field != OP_POINT_HIGH)) ||
                    (rst_field != 2'd0)) begin
                    st_d.cmd_stb[chan_i] = 1'b1;
                    st_d.cmd_op = op_field;
                    st_d.crc_op = rst_field;
                end
            end else begin
                st_d.ptr = '0;
            end
        end else if (cs_i && rd_i) begin
            st_d.ptr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o     = st_q.ptr;
    assign reg_we_o  = cs_i && wr_i && !at_base;
    assign cmd_stb_o = st_q.cmd_stb;
    assign cmd_op_o  = st_q.cmd_op;
    assign crc_op_o  = st_q.crc_op;

    // R1: a selected access always lands the pointer back on 0
    assert_ptr_return_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i && (rd_i || wr_i) && (ptr_o != '0)) |=> (ptr_o == '0));

    // R2: the upper bank is reachable only through point-high
    assert_upper_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i && wr_i && (ptr_o == '0) && (data_i[5:3] != OP_POINT_HIGH))
        |=> !ptr_o[PW-1]);

    // R3: a strobe follows only a register-0 write
    assert_cmd_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd_stb_o) |-> $past(cs_i && wr_i && (ptr_o == '0)));

    // R3: never more than one channel strobed
    assert_cmd_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_stb_o));

endmodule

// File: rtl/sio_wreg_file.sv
module sio_wreg_file
    import sio_regport_pkg::*;
#(
    parameter int DATA_W   = DATA_W_DEF,
    parameter int NUM_REGS = NUM_REGS_DEF,
    localparam int PW      = $clog2(NUM_REGS)
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     we_i,
    input  logic                                     chan_i,
    input  logic [PW-1:0]                            idx_i,
    input  logic [DATA_W-1:0]                        data_i,
    output logic [NUM_CH-1:0][NUM_REGS-1:0][DATA_W-1:0] wreg_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][NUM_REGS-1:0][DATA_W-1:0] regs;
        logic [DATA_W-1:0]                           vec;
        logic [DATA_W-1:0]                           mctl;
    } wfile_state_t;

    wfile_state_t wf_d, wf_q;

    always_comb begin
        wf_d = wf_q;
        if (we_i) begin
            if (idx_i == PW'(IDX_VEC)) begin
                wf_d.vec = data_i;
            end else if (idx_i == PW'(IDX_MCTL)) begin
                case (data_i[7:6])
                    MRST_ALL: begin
                        wf_d = '0;
                    end
                    MRST_CH_A: begin
                        wf_d.regs[0] = '0;
                        wf_d.mctl    = data_i & MCTL_KEEP_MASK;
                    end
                    MRST_CH_B: begin
                        wf_d.regs[1] = '0;
                        wf_d.mctl    = data_i & MCTL_KEEP_MASK;
                    end
                    default: begin
                        wf_d.mctl = data_i;
                    end
                endcase
            end else begin
                wf_d.regs[chan_i][idx_i] = data_i;
            end
        end
        // Slots of register 0 and of the shared registers stay empty in the
        // per-channel array, so the merge below is exact.
        for (int c = 0; c < NUM_CH; c++) begin
            wf_d.regs[c][0]        = '0;
            wf_d.regs[c][IDX_VEC]  = '0;
            wf_d.regs[c][IDX_MCTL] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wf_q <= '0;
        end else begin
            wf_q <= wf_d;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            if (r == IDX_VEC) begin : g_vec
                assign wreg_o[c][r] = wf_q.regs[c][r] | wf_q.vec;
            end else if (r == IDX_MCTL) begin : g_mctl
                assign wreg_o[c][r] = wf_q.regs[c][r] | wf_q.mctl;
            end else begin : g_own
                assign wreg_o[c][r] = wf_q.regs[c][r];
            end
        end
    end

    // R5: a vector write is seen through the shared copy
    assert_vec_shared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (idx_i == PW'(IDX_VEC))) |=> (wreg_o[1][IDX_VEC] == $past(data_i)));

    // R8: a single-channel reset leaves the shared vector untouched
    assert_chan_rst_keeps_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (idx_i == PW'(IDX_MCTL)) && (data_i[7] != data_i[6]))
        |=> (wreg_o[0][IDX_VEC] == $past(wreg_o[0][IDX_VEC])));

    // R9: a full reset empties the shared copies
    assert_full_rst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (idx_i == PW'(IDX_MCTL)) && (data_i[7:6] == MRST_ALL))
        |=> ((wreg_o[0][IDX_VEC] == '0) && (wreg_o[1][IDX_MCTL] == '0)));

endmodule

// File: rtl/sio_rd_mux.sv
module sio_rd_mux
    import sio_regport_pkg::*;
#(
    parameter int DATA_W   = DATA_W_DEF,
    parameter int NUM_REGS = NUM_REGS_DEF,
    localparam int PW      = $clog2(NUM_REGS)
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        chan_i,
    input  logic [PW-1:0]                               ptr_i,
    input  logic [2:0]                                  pend_a_i,
    input  logic [2:0]                                  pend_b_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]               dp_rr0_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]               dp_rr1_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]               dp_rr10_i,
    input  logic [NUM_CH-1:0][NUM_REGS-1:0][DATA_W-1:0] wreg_i,
    output logic [DATA_W-1:0]                           rdata_o
);

    logic [DATA_W-1:0] rdata_d;

    always_comb begin
        rdata_d = '0;
        case (ptr_i)
            PW'(IDX_STAT0):  rdata_d = dp_rr0_i[chan_i];
            PW'(IDX_STAT1):  rdata_d = dp_rr1_i[chan_i];
            PW'(IDX_VEC):    rdata_d = wreg_i[chan_i][IDX_VEC];
            PW'(IDX_PEND):   rdata_d = (chan_i == 1'b0) ?
                                       DATA_W'({2'b00, pend_a_i, pend_b_i}) : '0;
            PW'(IDX_MISC):   rdata_d = dp_rr10_i[chan_i];
            PW'(IDX_BRG_LO): rdata_d = wreg_i[chan_i][IDX_BRG_LO];
            PW'(IDX_BRG_HI): rdata_d = wreg_i[chan_i][IDX_BRG_HI];
            PW'(IDX_EXTCFG): rdata_d = wreg_i[chan_i][IDX_EXTCFG] & DATA_W'(EXTCFG_RD_MASK);
            default:         rdata_d = '0;
        endcase
    end

    assign rdata_o = rdata_d;

    // R7: the two reserved bits of the readback are always zero
    assert_extcfg_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_i == PW'(IDX_EXTCFG)) |-> ((rdata_o[2] == 1'b0) && (rdata_o[0] == 1'b0)));

    // R6: the pending summary is absent on channel B
    assert_pend_chan_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ptr_i == PW'(IDX_PEND)) && chan_i) |-> (rdata_o == '0));

endmodule

// File: rtl/sio_regport.sv
module sio_regport
    import sio_regport_pkg::*;
#(
    parameter int DATA_W   = DATA_W_DEF,
    parameter int NUM_REGS = NUM_REGS_DEF
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        cs_i,
    input  logic                                        chan_i,
    input  logic                                        rd_i,
    input  logic                                        wr_i,
    input  logic [DATA_W-1:0]                           data_i,
    output logic [DATA_W-1:0]                           data_o,
    output logic                                        data_oe_o,
    input  logic [2:0]                                  pend_a_i,
    input  logic [2:0]                                  pend_b_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]               dp_rr0_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]               dp_rr1_i,
    input  logic [NUM_CH-1:0][DATA_W-1:0]               dp_rr10_i,
    output logic [NUM_CH-1:0][NUM_REGS-1:0][DATA_W-1:0] wreg_o,
    output logic [NUM_CH-1:0]                           cmd_stb_o,
    output logic [2:0]                                  cmd_op_o,
    output logic [1:0]                                  crc_op_o
);

    localparam int PW = $clog2(NUM_REGS);

    logic [PW-1:0] ptr;
    logic          reg_we;

    sio_ptr_seq #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_i      (cs_i),
        .chan_i    (chan_i),
        .rd_i      (rd_i),
        .wr_i      (wr_i),
        .data_i    (data_i),
        .ptr_o     (ptr),
        .reg_we_o  (reg_we),
        .cmd_stb_o (cmd_stb_o),
        .cmd_op_o  (cmd_op_o),
        .crc_op_o  (crc_op_o)
    );

    sio_wreg_file #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_wfile (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (reg_we),
        .chan_i (chan_i),
        .idx_i  (ptr),
        .data_i (data_i),
        .wreg_o (wreg_o)
    );

    sio_rd_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_i    (chan_i),
        .ptr_i     (ptr),
        .pend_a_i  (pend_a_i),
        .pend_b_i  (pend_b_i),
        .dp_rr0_i  (dp_rr0_i),
        .dp_rr1_i  (dp_rr1_i),
        .dp_rr10_i (dp_rr10_i),
        .wreg_i    (wreg_o),
        .rdata_o   (data_o)
    );

    assign data_oe_o = cs_i && rd_i;

endmodule

// File: tb/sio_regport_tb.sv
module sio_regport_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, chan = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic doe;
    logic [2:0] pend_a = '0, pend_b = '0;
    logic [1:0][7:0] dp0, dp1, dp10;
    logic [1:0][15:0][7:0] wreg;
    logic [1:0] cmd_stb;
    logic [2:0] cmd_op;
    logic [1:0] crc_op;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] mdl [2][16];
    logic [7:0] vec_m, mctl_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_regport u_dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .chan_i(chan), .rd_i(rd), .wr_i(wr),
        .data_i(din), .data_o(dout), .data_oe_o(doe),
        .pend_a_i(pend_a), .pend_b_i(pend_b),
        .dp_rr0_i(dp0), .dp_rr1_i(dp1), .dp_rr10_i(dp10),
        .wreg_o(wreg), .cmd_stb_o(cmd_stb), .cmd_op_o(cmd_op), .crc_op_o(crc_op)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sel_byte(input int r);
        if (r >= 8) return 8'h08 | 8'(r % 8);
        return 8'(r);
    endfunction

    function automatic logic [7:0] exp_rd(input int ch, input int r);
        case (r)
            0:  return dp0[ch];
            1:  return dp1[ch];
            2:  return vec_m;
            3:  return (ch == 0) ? {2'b00, pend_a, pend_b} : 8'h00;
            10: return dp10[ch];
            12: return mdl[ch][12];
            13: return mdl[ch][13];
            15: return mdl[ch][15] & 8'hFA;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_w(input int ch, input int r);
        if (r == 2) return vec_m;
        if (r == 9) return mctl_m;
        return mdl[ch][r];
    endfunction

    task automatic acc_wr(input logic ch, input logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; chan = ch; wr = 1'b1; din = v;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic acc_rd(input logic ch, output logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; chan = ch; rd = 1'b1;
        #1 v = dout;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic reg_wr(input int ch, input int r, input logic [7:0] v);
        acc_wr(1'(ch), sel_byte(r));
        acc_wr(1'(ch), v);
    endtask

    task automatic reg_rd(input int ch, input int r, output logic [7:0] v);
        acc_wr(1'(ch), sel_byte(r));
        acc_rd(1'(ch), v);
    endtask

    task automatic chk_all_w(input string req);
        for (int c = 0; c < 2; c++)
            for (int r = 1; r < 16; r++)
                chk(req, {16'(c), 8'(r), wreg[c][r]}, {16'(c), 8'(r), exp_w(c, r)});
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        dp0  = {8'hB1, 8'hA0};
        dp1  = {8'hB3, 8'hA2};
        dp10 = {8'hBE, 8'hAD};
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 16; r++) mdl[c][r] = 8'h00;
        vec_m = 8'h00; mctl_m = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        #1;
        chk("R10 wreg zero", 32'(|wreg), 32'd0);
        chk("R10 no strobe", 32'(cmd_stb), 32'd0);
        acc_rd(1'b0, v);
        chk("R10 pointer at 0", 32'(v), 32'(dp0[0]));

        // R12: bus drive enable
        @(negedge clk); rd = 1'b1; cs = 1'b0; #1;
        chk("R12 oe without cs", 32'(doe), 32'd0);
        cs = 1'b1; chan = 1'b1; #1;
        chk("R12 oe with cs", 32'(doe), 32'd1);
        chk("R11 rr0 channel B", 32'(dout), 32'(dp0[1]));
        @(negedge clk); cs = 1'b0; rd = 1'b0; #1;
        chk("R12 oe idle", 32'(doe), 32'd0);

        // R1/R2: write sweep over both channels, both banks
        for (int c = 0; c < 2; c++) begin
            for (int r = 1; r < 16; r++) begin
                if (r == 2 || r == 9) continue;
                v = 8'((r * 37 + c * 101 + 3) % 256);
                reg_wr(c, r, v);
                mdl[c][r] = v;
                chk("R1 selected write", 32'(wreg[c][r]), 32'(v));
            end
            acc_rd(1'(c), v);
            chk("R1 pointer back to 0", 32'(v), 32'(dp0[c]));
        end
        chk_all_w("R2 no misdirected write");

        // R11/R7/R6: full readback sweep
        pend_a = 3'b101; pend_b = 3'b010;
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 16; r++) begin
                reg_rd(c, r, v);
                chk("R11 read mux", {8'(c), 8'(r), v}, {8'(c), 8'(r), exp_rd(c, r)});
            end
        reg_wr(0, 15, 8'hFF); mdl[0][15] = 8'hFF;
        reg_rd(0, 15, v);
        chk("R7 extcfg mask", 32'(v), 32'hFA);

        // R6: every pending pattern
        for (int k = 0; k < 64; k++) begin
            pend_a = 3'(k / 8); pend_b = 3'(k % 8);
            reg_rd(0, 3, v);
            chk("R6 pending on A", 32'(v), 32'(k));
        end
        reg_rd(1, 3, v);
        chk("R6 pending on B", 32'(v), 32'd0);

        // R3/R4: all command and reset codes on both channels
        for (int c = 0; c < 2; c++)
            for (int op = 0; op < 8; op++)
                for (int rc = 0; rc < 4; rc++) begin
                    logic strobe;
                    strobe = ((op >= 2) || (rc != 0));
                    acc_wr(1'(c), 8'(rc * 64 + op * 8));
                    chk("R3 strobe", 32'(cmd_stb), strobe ? 32'(1 << c) : 32'd0);
                    if (strobe) begin
                        chk("R3 op code", 32'(cmd_op), 32'(op));
                        chk("R4 reset code", 32'(crc_op), 32'(rc));
                    end
                    if (op == 1) begin
                        acc_rd(1'(c), v);
                        chk("R2 point-high reaches reg 8", 32'(v), 32'd0);
                    end
                    @(negedge clk);
                    chk("R3 single-cycle strobe", 32'(cmd_stb), 32'd0);
                end

        // R5: shared registers
        reg_wr(1, 2, 8'h5A); vec_m = 8'h5A;
        chk("R5 vector seen on A", 32'(wreg[0][2]), 32'h5A);
        chk("R5 vector seen on B", 32'(wreg[1][2]), 32'h5A);
        reg_rd(0, 2, v);
        chk("R5 vector readback", 32'(v), 32'h5A);
        reg_wr(0, 9, 8'h0B); mctl_m = 8'h0B;
        chk("R5 master control on B", 32'(wreg[1][9]), 32'h0B);

        // R8: channel resets
        reg_wr(0, 9, 8'h88);
        for (int r = 0; r < 16; r++) mdl[0][r] = 8'h00;
        mctl_m = 8'h08;
        chk_all_w("R8 channel A reset");
        reg_wr(1, 4, 8'h44); mdl[1][4] = 8'h44;
        reg_wr(1, 9, 8'h45);
        for (int r = 0; r < 16; r++) mdl[1][r] = 8'h00;
        mctl_m = 8'h05;
        chk_all_w("R8 channel B reset");

        // R9: full reset
        reg_wr(0, 4, 8'h33); mdl[0][4] = 8'h33;
        reg_wr(1, 11, 8'h77); mdl[1][11] = 8'h77;
        reg_wr(1, 9, 8'hC0);
        chk("R9 full reset", 32'(|wreg), 32'd0);
        for (int r = 0; r < 16; r++) begin mdl[0][r] = 8'h00; mdl[1][r] = 8'h00; end
        vec_m = 8'h00; mctl_m = 8'h00;

        // R13: strobes without chip select
        @(negedge clk); cs = 1'b0; chan = 1'b0; wr = 1'b1; din = 8'h06;
        @(negedge clk); din = 8'h77;
        @(negedge clk); wr = 1'b0;
        chk("R13 register untouched", 32'(wreg[0][6]), 32'd0);
        acc_rd(1'b0, v);
        chk("R13 pointer untouched", 32'(v), 32'(dp0[0]));
        chk_all_w("R13 all registers untouched");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule